// File: doc/BRIEF.md
# Real-Time Clock Seconds Prescaler

This block sits at the input of a real-time clock and divides a crystal clock down to a one-second tick that the calendar counters downstream consume. Software talks to it over a small register bus running on the system clock. A control word at offset 0x00 holds four fields: a run request, a read-only running flag, a 24-hour format flag and a tick-source mode. A compare word at offset 0x3C holds the divide value used in the programmable mode.

Two ways of producing the tick exist. In the fixed mode, which is the reset default, the crystal is assumed to run at 32768 Hz and a counter wraps every 32768 crystal cycles. In the compare mode the counter wraps after reaching the programmed compare value, so software writes the crystal rate minus one and any rate from 32000 Hz up to 2^22 Hz yields one tick per second.

The run request crosses into the crystal domain through a synchronizer. The actual running state crosses back through a second synchronizer and shows up as the running flag. Software must clear the run request and wait for the flag to read 0 before it changes the mode or the compare value. While the flag reads 1, the block discards writes to those two fields. The tick output is a plain one-crystal-cycle pulse with no back-pressure, because the calendar logic that receives it must take every second.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the control word at 0x00 reads 0, the compare word at 0x3C reads 32767 (0x7FFF) and tick_o is low.
- R2: Writing 1 to control bit 7 (run request) starts the crystal-side counter, and control bit 6 (running flag) then reads 1.
- R3: After bit 7 is cleared, bit 6 keeps reading 1 until the crystal side has stopped, and reads 0 within 8 system-clock cycles of the write when the crystal runs at 14 ns or faster.
- R4: With control bit 4 = 1 (compare mode), tick_o pulses once every C+1 crystal cycles, where C is the low 22 bits of the compare word. A value of 0 makes tick_o stay high on every crystal cycle.
- R5: With control bit 4 = 0 (fixed mode), tick_o pulses once every 32768 crystal cycles, whatever the compare word holds.
- R6: While bit 6 reads 1, writes to control bit 4 and to the compare word are ignored. A write to bit 7 in the same period still takes effect.
- R7: Control bit 5 (24-hour flag) can be written and read back at any time, including while the counter runs.
- R8: Control bit 6 is read-only, and a write of 1 to it leaves it reading 0 while the counter is stopped.
- R9: tick_o stays low while the counter is stopped, and the count restarts from zero each time the counter starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (register bus) clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| xtal_clk | input | 1 | Crystal clock |
| wr_en | input | 1 | Register write strobe, sampled on clk |
| addr | input | 8 | Register byte offset (0x00 control, 0x3C compare) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_o | output | 1 | One-second tick, one crystal cycle wide, in the xtal_clk domain |

## Verification
The bench sweeps compare values from 0 up to 17 and checks the tick spacing in crystal cycles. A design that compared with an off-by-one limit, or that stalled for a cycle at the wrap, would measure C or C+2 instead of C+1, and a compare value of 0 would hang it or leave gaps. It times the fall of the running flag after the run request clears, which catches a flag that skips the synchronizer and drops at once or never drops. It rewrites the mode and the compare word while running and then checks the read-back and the unchanged tick spacing, which exposes a missing write guard. A fixed-mode run with a small compare value loaded shows whether the mode bit really selects the 32768 divide.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] CMP_OFS  = 8'h3C;
  localparam int RUN_REQ_BIT = 7;
  localparam int RUNNING_BIT = 6;
  localparam int H24_BIT     = 5;
  localparam int MODE_BIT    = 4;

  typedef enum logic {
    SRC_FIXED   = 1'b0,
    SRC_COMPARE = 1'b1
  } tick_src_e;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CMP_W  = 22,
  parameter logic [CMP_W-1:0] CMP_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  output logic              run_req,
  output logic              h24,
  output tick_src_e         src,
  output logic [CMP_W-1:0]  cmp,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      h24     <= 1'b0;
      src     <= SRC_FIXED;
      cmp     <= CMP_RST;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CTRL_OFS)) begin
        run_req <= wdata[RUN_REQ_BIT];
        h24     <= wdata[H24_BIT];
        if (!running) src <= tick_src_e'(wdata[MODE_BIT]);
      end else if (addr == ADDR_W'(CMP_OFS)) begin
        if (!running) cmp <= wdata[CMP_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_OFS)) begin
      rdata[RUN_REQ_BIT] = run_req;
      rdata[RUNNING_BIT] = running;
      rdata[H24_BIT]     = h24;
      rdata[MODE_BIT]    = src;
    end else if (addr == ADDR_W'(CMP_OFS)) begin
      rdata[CMP_W-1:0] = cmp;
    end
  end
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_pkg::*;
#(
  parameter int CMP_W      = 22,
  parameter int FIXED_BITS = 15
) (
  input  logic             xtal_clk,
  input  logic             rst_n,
  input  logic             run,
  input  tick_src_e        src,
  input  logic [CMP_W-1:0] cmp,
  output logic             tick,
  output logic [CMP_W-1:0] cnt
);
  localparam logic [CMP_W-1:0] FIXED_LIMIT = CMP_W'((64'd1 << FIXED_BITS) - 64'd1);

  logic [CMP_W-1:0] limit;
  assign limit = (src == SRC_COMPARE) ? cmp : FIXED_LIMIT;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CMP_W       = 22,
  parameter int FIXED_BITS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_o
);
  localparam logic [CMP_W-1:0] CMP_RST = CMP_W'((64'd1 << FIXED_BITS) - 64'd1);

  logic             run_req;
  logic             h24;
  tick_src_e        src_q;
  logic [CMP_W-1:0] cmp_q;
  logic             run;
  logic             running;
  logic [CMP_W-1:0] cnt;
  logic             unused_h24;

  assign unused_h24 = h24;

  rtc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W), .CMP_RST(CMP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .running(running), .run_req(run_req), .h24(h24), .src(src_q),
    .cmp(cmp_q), .rdata(rdata)
  );

  rtc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(xtal_clk), .rst_n(rst_n), .d(run_req), .q(run)
  );

  rtc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .d(run), .q(running)
  );

  rtc_divider #(.CMP_W(CMP_W), .FIXED_BITS(FIXED_BITS)) u_div (
    .xtal_clk(xtal_clk), .rst_n(rst_n), .run(run), .src(src_q),
    .cmp(cmp_q), .tick(tick_o), .cnt(cnt)
  );
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int CMP_W = 22
) (
  input logic             clk,
  input logic             xtal_clk,
  input logic             rst_n,
  input logic             running,
  input logic             src,
  input logic [CMP_W-1:0] cmp,
  input logic             run,
  input logic             tick,
  input logic [CMP_W-1:0] cnt
);
  // R6: compare word frozen while the running flag is up
  p_cmp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(cmp));

  // R6: mode bit frozen while the running flag is up
  p_src_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(src));

  // R9: no tick follows a stopped cycle
  p_no_idle_tick_r9: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    !run |=> !tick);

  // R4: every tick coincides with the counter back at zero
  p_tick_at_wrap_r4: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    tick |-> (cnt == '0));

  // R9: the count starts from zero when the counter starts
  p_start_zero_r9: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.CMP_W(CMP_W)) u_chk (
  .clk(clk), .xtal_clk(xtal_clk), .rst_n(rst_n), .running(running),
  .src(src_q), .cmp(cmp_q), .run(run), .tick(tick_o), .cnt(cnt)
);

// File: tb/sim_rtc_prescaler.sv
module sim_rtc_prescaler;
  logic        clk = 1'b0;
  logic        xtal_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;
  always #7 xtal_clk = ~xtal_clk;

  rtc_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
  );

  localparam int NVEC = 5;
  localparam logic [21:0] CMP_VEC [NVEC] = '{22'd3, 22'd9, 22'd1, 22'd0, 22'd17};
  localparam int          PER_VEC [NVEC] = '{4, 10, 2, 1, 18};

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_running(input logic want, output int cyc);
    logic [31:0] v;
    cyc = 0;
    do begin
      rd(8'h00, v);
      cyc++;
    end while (v[6] != want && cyc < 100);
  endtask

  task automatic measure(output int per);
    int n = 0;
    do begin @(negedge xtal_clk); n++; end while (!tick_o && n < 70000);
    per = 0;
    do begin @(negedge xtal_clk); per++; end while (!tick_o && per < 70000);
  endtask

  task automatic stop_counter();
    int c;
    wr(8'h00, 32'h0);
    wait_running(1'b0, c);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int per, cyc, nt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h3C, v); check("R1 cmp", v, 32'h7FFF);
    check("R1 tick", tick_o, 0);

    // R4 table of compare values
    for (int i = 0; i < NVEC; i++) begin
      stop_counter();
      wr(8'h3C, 32'(CMP_VEC[i]));
      wr(8'h00, 32'h90);
      wait_running(1'b1, cyc);
      rd(8'h00, v); check("R2 running", v[6], 1);
      rd(8'h3C, v); check("R4 cmp readback", v, 32'(CMP_VEC[i]));
      measure(per); check("R4 period", per, PER_VEC[i]);
    end

    // R6 writes to mode and compare ignored while running (cmp=17 running)
    wr(8'h3C, 32'd3);
    wr(8'h00, 32'h80);
    rd(8'h3C, v); check("R6 cmp kept", v, 17);
    rd(8'h00, v); check("R6 mode kept", v[4], 1);
    check("R6 run req kept", v[7], 1);
    measure(per); check("R6 period", per, 18);

    // R7 24-hour flag while running
    wr(8'h00, 32'hB0);
    rd(8'h00, v); check("R7 h24 set", v[5], 1);
    wr(8'h00, 32'h90);
    rd(8'h00, v); check("R7 h24 clear", v[5], 0);

    // R3 running flag falls after synchronization
    wr(8'h00, 32'h10);
    cyc = 0;
    do begin rd(8'h00, v); cyc++; end while (v[6] && cyc < 100);
    check("R3 flag not instant", (cyc >= 2) ? 1 : 0, 1);
    check("R3 flag falls in time", (cyc <= 8) ? 1 : 0, 1);

    // R9 no ticks while stopped
    nt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge xtal_clk);
      if (tick_o) nt++;
    end
    check("R9 idle ticks", nt, 0);

    // R8 running flag not writable
    wr(8'h00, 32'h40);
    rd(8'h00, v); check("R8 flag ro", v[6], 0);
    repeat (10) @(negedge clk);
    rd(8'h00, v); check("R8 flag ro later", v[6], 0);

    // R9 restart from zero: first tick after start lands at C+1 spacing
    wr(8'h3C, 32'd5);
    wr(8'h00, 32'h90);
    wait_running(1'b1, cyc);
    measure(per); check("R9 restart period", per, 6);

    // R5 fixed mode ignores compare word (5)
    stop_counter();
    wr(8'h00, 32'h80);
    wait_running(1'b1, cyc);
    rd(8'h00, v); check("R5 mode fixed", v[4], 0);
    measure(per); check("R5 period", per, 32768);

    done = 1;
    summary();
  end
endmodule